// File: doc/BRIEF.md
# Logic Capture Sampling and Trigger Front End

This block sits between sixteen logic probe inputs and a 32-bit-wide capture memory. A host programs it through a small word-addressed register port. The host sets a channel-enable mask, a sample-rate divider, a trigger pattern with per-channel edge selection, a stop count and a memory mode. It then arms the block.

Once armed, the block takes one sample from the masked inputs on every divider tick. It compares each sample with the trigger condition. From the triggering sample onward, it packs consecutive samples two per memory word and writes each word at an auto-incrementing pointer. When the stop count runs out, it returns to idle.

The host can poll a 7-bit status field, the write pointer, the remaining stop count and a millisecond run timer. A fixed identification word at the trigger-select address lets the host confirm that the link works.

Top module: `logic_capture_front`

## Requirements
- R1: Reading word address 2 always returns 0x12345678. A write to that address (which sets the trigger) does not change what it reads.
- R2: With divider reload N (word address 1), a sample is taken every N+1 clock cycles. A reload of 0 samples on every cycle. Memory words therefore appear every 2·(N+1) cycles.
- R3: Channels cleared in the enable mask (word address 0, bits 15:0) read as 0, both in trigger evaluation and in stored data.
- R4: The earlier sample of each pair goes in bits 15:0 and the later one in bits 31:16. Each word is written at the current write pointer, which then increments, so consecutive words go to 0, 1, 2, and so on after a pointer reset.
- R5: A participating channel whose edge bit is clear matches when its sample bit equals its value bit. The trigger fires only when every participating channel matches in the same sample.
- R6: A participating channel whose edge bit is set matches only when its bit changes to the value bit: the previous sample differs from the value and the current sample equals it. A level that is held from before arming does not fire.
- R7: The control register at word address 3 arms the block when bit 2 is written as 1. Bits 31:16 of that write select the participating channels. An empty selection fires on the first sample. Samples taken before the trigger are not stored, and the triggering sample is the first one stored.
- R8: The stop count (word address 4) resets to 2^MEM_AW − 5 and can be reloaded by a write. It decrements once per memory word. Capture ends and the block goes idle when the count reaches 0, and a read returns the remaining count.
- R9: The memory-control register (word address 5) works as follows. Bit 0 written as 1 resets the write pointer (read at word address 6) to 0. Bit 1 enables memory writes. With bit 1 clear, no word is written and the stop count is left unchanged.
- R10: Reading word address 3 returns a status field in bits 6:0, with bits 31:7 zero:
  - bit 0: half word pending
  - bit 2: armed, waiting for the trigger
  - bit 4: no half word pending
  - bit 5: capture running
  - bit 6: stop count nonzero
  - bits 1 and 3: 0
- R11: The duration register (word address 7) counts whole milliseconds of MS_CYCLES clocks each while capture runs. It holds its value when capture is not running. A control write with bit 3 set clears it.
- R12: A control write with bit 2 clear stops sampling at once, and no further words are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_i | input | NUM_CH | Probe inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_we_o | output | 1 | Capture memory write strobe |
| mem_addr_o | output | MEM_AW | Capture memory word address |
| mem_wdata_o | output | 2*NUM_CH | Packed sample pair |

## Verification
The bench sweeps the divider reload over its low values while the probe inputs ramp. It measures the spacing of the memory writes and the difference between the two halves of each word. An off-by-one reload or swapped halves shows up as a wrong interval or a wrong step.

The trigger cases are set up so that a faulty design stores something visible:
- A level pattern held before arming would fire a design that ignores the edge bits.
- A value on a disabled channel would fire a design that skips the enable mask.
- A pre-trigger sample would appear in the first stored word of a design that stores samples before the trigger.

The stop-count, write-mode-off and disarm cases count the words written. A design that overruns, writes while disabled, or keeps writing after disarm is caught by the extra words.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
  localparam logic [31:0] TEST_WORD = 32'h1234_5678;

  localparam logic [2:0] A_CHEN   = 3'd0;
  localparam logic [2:0] A_DIV    = 3'd1;
  localparam logic [2:0] A_TRIG   = 3'd2;
  localparam logic [2:0] A_CTRL   = 3'd3;
  localparam logic [2:0] A_COUNT  = 3'd4;
  localparam logic [2:0] A_MEMCTL = 3'd5;
  localparam logic [2:0] A_WPTR   = 3'd6;
  localparam logic [2:0] A_DUR    = 3'd7;

  localparam int CTRL_ARM   = 2;
  localparam int CTRL_CLR   = 3;
  localparam int MEM_PRST   = 0;
  localparam int MEM_WMODE  = 1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN} cap_state_e;
endpackage

// File: rtl/lcap_divider.sv
module lcap_divider #(
  parameter int DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] reload_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q == '0)   cnt_q <= reload_i;
    else                    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lcap_trigger.sv
module lcap_trigger #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] smp_i,
  input  logic [NUM_CH-1:0] value_i,
  input  logic [NUM_CH-1:0] edge_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              fire_o
);
  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] hit;

  // edge channels also need the previous sample to differ from the value
  assign hit    = ~(smp_i ^ value_i) & (~edge_i | (prev_q ^ value_i));
  assign fire_o = &(~mask_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= '0;
    else if (tick_i) prev_q <= smp_i;
  end
endmodule

// File: rtl/lcap_packer.sv
module lcap_packer #(
  parameter int NUM_CH   = 16,
  parameter int MEM_AW   = 18,
  parameter int CNT_W    = 19,
  parameter int CNT_INIT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                store_i,
  input  logic [NUM_CH-1:0]   smp_i,
  input  logic                clr_half_i,
  input  logic                ptr_rst_i,
  input  logic                cnt_load_i,
  input  logic [CNT_W-1:0]    cnt_val_i,
  output logic                mem_we_o,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic [2*NUM_CH-1:0] mem_wdata_o,
  output logic [MEM_AW-1:0]   wr_ptr_o,
  output logic [CNT_W-1:0]    cnt_left_o,
  output logic                half_o,
  output logic                last_o
);
  logic [NUM_CH-1:0] lo_q;
  logic              half_q;
  logic [MEM_AW-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              word_done;

  assign word_done  = store_i & half_q;
  assign last_o     = word_done & (cnt_q == CNT_W'(1));
  assign wr_ptr_o   = ptr_q;
  assign cnt_left_o = cnt_q;
  assign half_o     = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q        <= '0;
      half_q      <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= word_done;
      if (clr_half_i) begin
        half_q <= 1'b0;
      end else if (store_i) begin
        if (!half_q) begin
          lo_q   <= smp_i;
          half_q <= 1'b1;
        end else begin
          half_q      <= 1'b0;
          mem_wdata_o <= {smp_i, lo_q};
          mem_addr_o  <= ptr_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= CNT_W'(CNT_INIT);
    end else begin
      if (ptr_rst_i)      ptr_q <= '0;
      else if (word_done) ptr_q <= ptr_q + 1'b1;
      if (cnt_load_i)                       cnt_q <= cnt_val_i;
      else if (word_done && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lcap_ms_timer.sv
module lcap_ms_timer #(
  parameter int MS_CYCLES = 100000,
  parameter int DUR_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [DUR_W-1:0] dur_o
);
  localparam int PW = (MS_CYCLES > 2) ? $clog2(MS_CYCLES) : 1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      dur_o <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      dur_o <= '0;
    end else if (run_i) begin
      if (pre_q == PW'(MS_CYCLES - 1)) begin
        pre_q <= '0;
        dur_o <= dur_o + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/logic_capture_front.sv
module logic_capture_front #(
  parameter int NUM_CH    = 16,
  parameter int MEM_AW    = 18,
  parameter int DIV_W     = 24,
  parameter int MS_CYCLES = 100000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   ch_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                mem_we_o,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic [2*NUM_CH-1:0] mem_wdata_o
);
  import lcap_pkg::*;

  localparam int CNT_W     = MEM_AW + 1;
  localparam int STOP_INIT = (1 << MEM_AW) - 5;

  cap_state_e        state_q;
  logic [NUM_CH-1:0] chen_q, tval_q, tedge_q, tmask_q;
  logic [DIV_W-1:0]  div_q;
  logic              mem_wmode_q;

  logic              ctrl_wr, tick_s, fire_s, store_s, last_s, half_s;
  logic              armed_s, run_s, cnt_zero_s;
  logic [NUM_CH-1:0] smp_s;
  logic [MEM_AW-1:0] wptr_s;
  logic [CNT_W-1:0]  cnt_s;
  logic [31:0]       dur_s;
  logic [6:0]        status_s;

  assign ctrl_wr    = reg_we_i && (reg_addr_i == A_CTRL);
  assign smp_s      = ch_i & chen_q;
  assign armed_s    = (state_q == S_ARMED);
  assign run_s      = (state_q == S_RUN);
  assign cnt_zero_s = (cnt_s == '0);
  assign store_s    = tick_s && mem_wmode_q && !cnt_zero_s && !ctrl_wr &&
                      (run_s || (armed_s && fire_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chen_q      <= '1;
      div_q       <= '0;
      tval_q      <= '0;
      tedge_q     <= '0;
      tmask_q     <= '0;
      mem_wmode_q <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CHEN:   chen_q      <= reg_wdata_i[NUM_CH-1:0];
        A_DIV:    div_q       <= reg_wdata_i[DIV_W-1:0];
        A_TRIG: begin
          tedge_q <= reg_wdata_i[16 +: NUM_CH];
          tval_q  <= reg_wdata_i[NUM_CH-1:0];
        end
        A_CTRL:   tmask_q     <= reg_wdata_i[16 +: NUM_CH];
        A_MEMCTL: mem_wmode_q <= reg_wdata_i[MEM_WMODE];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
    end else if (ctrl_wr) begin
      state_q <= reg_wdata_i[CTRL_ARM] ? S_ARMED : S_IDLE;
    end else begin
      case (state_q)
        S_ARMED: if (tick_s && fire_s) state_q <= cnt_zero_s ? S_IDLE : S_RUN;
        S_RUN:   if (last_s || cnt_zero_s) state_q <= S_IDLE;
        default: ;
      endcase
    end
  end

  lcap_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .reload_i (div_q),
    .restart_i(reg_we_i && reg_addr_i == A_DIV),
    .tick_o   (tick_s)
  );

  lcap_trigger #(.NUM_CH(NUM_CH)) u_trig (
    .clk_i, .rst_ni,
    .tick_i (tick_s),
    .smp_i  (smp_s),
    .value_i(tval_q),
    .edge_i (tedge_q),
    .mask_i (tmask_q),
    .fire_o (fire_s)
  );

  lcap_packer #(.NUM_CH(NUM_CH), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .CNT_INIT(STOP_INIT)) u_pack (
    .clk_i, .rst_ni,
    .store_i    (store_s),
    .smp_i      (smp_s),
    .clr_half_i (ctrl_wr),
    .ptr_rst_i  (reg_we_i && reg_addr_i == A_MEMCTL && reg_wdata_i[MEM_PRST]),
    .cnt_load_i (reg_we_i && reg_addr_i == A_COUNT),
    .cnt_val_i  (reg_wdata_i[CNT_W-1:0]),
    .mem_we_o,
    .mem_addr_o,
    .mem_wdata_o,
    .wr_ptr_o   (wptr_s),
    .cnt_left_o (cnt_s),
    .half_o     (half_s),
    .last_o     (last_s)
  );

  lcap_ms_timer #(.MS_CYCLES(MS_CYCLES), .DUR_W(32)) u_ms (
    .clk_i, .rst_ni,
    .run_i(run_s),
    .clr_i(ctrl_wr && reg_wdata_i[CTRL_CLR]),
    .dur_o(dur_s)
  );

  assign status_s = {!cnt_zero_s, run_s, !half_s, 1'b0, armed_s, 1'b0, half_s};

  always_comb begin
    case (reg_addr_i)
      A_CHEN:   reg_rdata_o = 32'(chen_q);
      A_DIV:    reg_rdata_o = 32'(div_q);
      A_TRIG:   reg_rdata_o = TEST_WORD;
      A_CTRL:   reg_rdata_o = 32'(status_s);
      A_COUNT:  reg_rdata_o = 32'(cnt_s);
      A_MEMCTL: reg_rdata_o = {30'b0, mem_wmode_q, 1'b0};
      A_WPTR:   reg_rdata_o = 32'(wptr_s);
      default:  reg_rdata_o = dur_s;
    endcase
  end
endmodule

// File: rtl/lcap_chk.sv
module lcap_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_we,
  input logic        wmode,
  input logic        armed,
  input logic        running,
  input logic        cnt_zero,
  input logic [2:0]  addr,
  input logic [31:0] rdata
);
  // R4
  pair_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> !mem_we);
  // R9
  wmode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> $past(wmode));
  // R8
  stop_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_zero |=> !running);
  // R7
  run_from_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running) |-> $past(armed));
  // R10
  status_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == 3'd3) |-> (rdata[31:7] == 25'd0));
endmodule

bind logic_capture_front lcap_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mem_we  (mem_we_o),
  .wmode   (mem_wmode_q),
  .armed   (armed_s),
  .running (run_s),
  .cnt_zero(cnt_zero_s),
  .addr    (reg_addr_i),
  .rdata   (reg_rdata_o)
);

// File: tb/logic_capture_front_tb_top.sv
module logic_capture_front_tb_top;
  localparam int NUM_CH = 16;
  localparam int MEM_AW = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [15:0] ch_set = '0;
  logic [15:0] ramp_cnt = '0;
  logic        ramp = 1'b0;
  logic [15:0] ch;

  int tests = 0, fails = 0, cyc = 0, nwr = 0;
  int last_t = 0, prev_t = 0;
  logic [31:0] last_data;
  logic [MEM_AW-1:0] last_addr;
  logic [31:0] wlog [0:255];
  logic [MEM_AW-1:0] alog [0:255];

  assign ch = ramp ? ramp_cnt : ch_set;

  always #2 clk = ~clk;

  logic_capture_front #(.NUM_CH(NUM_CH), .MEM_AW(MEM_AW), .DIV_W(8), .MS_CYCLES(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ch_i(ch),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(negedge clk) ramp_cnt <= ramp_cnt + 16'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      if (nwr < 256) begin
        wlog[nwr] = mem_wdata;
        alog[nwr] = mem_addr;
      end
      nwr = nwr + 1;
      prev_t = last_t;
      last_t = cyc;
      last_data = mem_wdata;
      last_addr = mem_addr;
    end
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: got %0d cycles, expected under 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_words(input int target);
    for (int i = 0; i < 2000 && nwr < target; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // reset state
    rd(3'd2, v); chk(v == 32'h12345678, "R1 test word", v, 32'h12345678);
    rd(3'd4, v); chk(v == 32'd59, "R8 reset count", v, 32'd59);
    rd(3'd3, v); chk(v == 32'h50, "R10 reset status", v, 32'h50);
    rd(3'd6, v); chk(v == 32'd0, "R9 reset pointer", v, 32'd0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk(v == 32'h12345678, "R1 id after trig write", v, 32'h12345678);

    // divider sweep with ramp, R2 R3 R4
    ramp = 1'b1;
    for (int n = 0; n < 4; n++) begin
      wr(3'd5, 32'h1); wr(3'd5, 32'h2);
      wr(3'd0, 32'h00FF); wr(3'd1, n); wr(3'd4, 32'd50);
      wr(3'd2, 32'h0); base = nwr;
      wr(3'd3, 32'h0000_0004);
      wait_words(base + 3);
      chk(last_t - prev_t == 2 * (n + 1), "R2 word interval", last_t - prev_t, 2 * (n + 1));
      chk(last_data[31:16] == ((last_data[15:0] + n + 1) & 16'h00FF), "R4 pair order",
          last_data, {(last_data[15:0] + 16'(n + 1)) & 16'h00FF, last_data[15:0]});
      chk((last_data & 32'hFF00_FF00) == 0, "R3 disabled bits zero", last_data & 32'hFF00FF00, 0);
      chk(last_addr == 2, "R4 third word address", 32'(last_addr), 2);
      wr(3'd3, 32'h0); base = nwr;
      wait_cyc(12);
      chk(nwr == base, "R12 disarm stops writes", nwr - base, 0);
    end
    ramp = 1'b0;

    // level trigger R5 R7
    wr(3'd0, 32'hFFFF); wr(3'd1, 32'h0); wr(3'd5, 32'h1); wr(3'd5, 32'h2);
    ch_set = 16'h0030;
    wr(3'd2, 32'h0000_0005); base = nwr;
    wr(3'd3, 32'h000F_0004);
    wait_cyc(10);
    chk(nwr == base, "R5 no fire on mismatch", nwr - base, 0);
    rd(3'd3, v); chk((v & 32'h24) == 32'h04, "R10 armed status", v & 32'h24, 32'h04);
    ch_set = 16'h0135;
    wait_cyc(6);
    chk(nwr > base, "R5 level fires", nwr - base, 1);
    chk(wlog[base] == 32'h0135_0135, "R7 first stored is trigger sample", wlog[base], 32'h01350135);
    chk(alog[base] == 0, "R4 first address", 32'(alog[base]), 0);
    wr(3'd3, 32'h0);

    // edge trigger R6
    ch_set = 16'h0001;
    wr(3'd2, 32'h0001_0001); base = nwr;
    wr(3'd3, 32'h0001_0004);
    wait_cyc(12);
    chk(nwr == base, "R6 held level ignored", nwr - base, 0);
    ch_set = 16'h0000; wait_cyc(4);
    chk(nwr == base, "R6 no fire on low", nwr - base, 0);
    ch_set = 16'h0001; wait_cyc(6);
    chk(nwr > base && wlog[base] == 32'h0001_0001, "R6 edge fires", wlog[base], 32'h00010001);
    wr(3'd3, 32'h0);

    // disabled channel in trigger R3
    wr(3'd0, 32'h00FF); ch_set = 16'hFFFF;
    wr(3'd2, 32'h0000_0100); base = nwr;
    wr(3'd3, 32'h0100_0004);
    wait_cyc(15);
    chk(nwr == base, "R3 disabled channel cannot trigger", nwr - base, 0);
    wr(3'd3, 32'h0);

    // stop count R8 R10
    wr(3'd0, 32'hFFFF); ch_set = 16'h1234;
    wr(3'd5, 32'h1); wr(3'd5, 32'h2); wr(3'd4, 32'd3);
    base = nwr;
    wr(3'd3, 32'h0000_0004);
    wait_cyc(20);
    chk(nwr - base == 3, "R8 exact word count", nwr - base, 3);
    rd(3'd4, v); chk(v == 0, "R8 count exhausted", v, 0);
    rd(3'd6, v); chk(v == 3, "R4 pointer after three", v, 3);
    rd(3'd3, v); chk(v == 32'h10, "R10 idle after stop", v, 32'h10);

    // write mode off R9
    wr(3'd5, 32'h1); wr(3'd5, 32'h0);
    rd(3'd6, v); chk(v == 0, "R9 pointer reset", v, 0);
    wr(3'd4, 32'd10); base = nwr;
    wr(3'd3, 32'h0000_0004);
    wait_cyc(20);
    chk(nwr == base, "R9 no write without mode", nwr - base, 0);
    rd(3'd4, v); chk(v == 10, "R9 count untouched", v, 10);
    wr(3'd3, 32'h0);

    // duration R11
    wr(3'd3, 32'h8);
    rd(3'd7, v); chk(v == 0, "R11 cleared", v, 0);
    wr(3'd5, 32'h2); wr(3'd1, 32'd7); wr(3'd4, 32'd50);
    wr(3'd3, 32'h0000_000C);
    wait_cyc(45);
    rd(3'd7, v); chk(v >= 3 && v <= 5, "R11 elapsed ms", v, 4);
    wr(3'd3, 32'h0);
    rd(3'd7, base);
    wait_cyc(30);
    rd(3'd7, v); chk(v == base, "R11 holds when idle", v, base);
    wr(3'd3, 32'h8);
    rd(3'd7, v); chk(v == 0, "R11 clear", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule